// File: doc/BRIEF.md
# Warp Stall-Reason Statistics Unit

This unit sits beside an issue scheduler and samples the state of every resident warp slot on each clock. Each resident warp that did not issue in that cycle is charged to exactly one stall category. Warps that were ready but passed over go to "not selected". The others are classified by the hazard holding them back. A warp with no flag raised goes to "other". Two more counters record whether the single issue slot was used (an issue cycle) or went unused (an empty slot). Together these give a profile of whether a workload is latency bound or has surplus ready warps.

All counters saturate rather than wrap. A single synchronous clear pulse resets all of them together. A registered read port returns one counter per address. The unit does not choose which warp issues and performs no reporting of its own.

Top module: `warp_stall_stats`

## Requirements
- R1: A cycle with at least one resident warp flagged selected adds one to the issue counter (address 0). Any other cycle adds one to the empty-slot counter (address 1). A selected resident warp is not charged to any stall category.
- R2: A resident, unselected warp whose eligible flag is set is charged to not-selected (address 2), whatever stall flags it also shows.
- R3: A resident, unselected, non-eligible warp with the long-memory wait flag set is charged to long scoreboard (address 3). This holds whatever other stall flags it shows.
- R4: Otherwise, a shared-memory wait flag charges short scoreboard (address 4), ahead of the pipe and dependency flags.
- R5: Otherwise, a memory-pipe-full flag charges pipe throughput (address 5), ahead of the dependency flag.
- R6: Otherwise, a fixed-latency dependency flag charges wait (address 6).
- R7: A resident, unselected, non-eligible warp with no stall flag is charged to other (address 7).
- R8: Non-resident warp slots (valid low) are ignored by every counter, whatever their other flags show.
- R9: Each counter is CNT_W bits (default 32) and holds at its all-ones value instead of wrapping.
- R10: A clear pulse zeroes every counter on the next edge and takes precedence over that cycle's increments.
- R11: rd_data shows the counter addressed by rd_addr one cycle after the address is presented. Addresses 8 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of all counters |
| warp_valid | input | NUM_WARPS | Warp slot is resident |
| warp_elig | input | NUM_WARPS | Warp has its next instruction ready |
| warp_sel | input | NUM_WARPS | Warp was chosen for the issue slot this cycle |
| wait_long_mem | input | NUM_WARPS | Waiting on a global/local memory load |
| wait_shared_mem | input | NUM_WARPS | Waiting on a shared-memory operation |
| mem_pipe_full | input | NUM_WARPS | Blocked by a saturated memory I/O pipeline |
| dep_wait | input | NUM_WARPS | Waiting on a fixed-latency arithmetic result |
| rd_addr | input | 4 | Counter address |
| rd_data | output | CNT_W | Addressed counter value, one cycle later |

## Verification
The assertions check on every cycle that per-warp classification is one-hot and silent for empty slots. They also check that the category increments plus issuing warps add up to the number of resident warps, and that each counter is monotonic, holds at saturation and zeroes after a clear. Only the directed scenarios can show the priority order between stall flags with concrete counts. The same applies to the exact saturation value, the precedence of clear over a live increment, the out-of-range read value, and the one-cycle read latency.

// File: rtl/warp_stall_stats_pkg.sv
package warp_stall_stats_pkg;
  localparam int NUM_CNT   = 8;
  localparam int NUM_STALL = 6;
  localparam int ADDR_W    = 4;

  typedef enum logic [ADDR_W-1:0] {
    CTR_ISSUE   = 4'd0,
    CTR_EMPTY   = 4'd1,
    CTR_NOTSEL  = 4'd2,
    CTR_LONGSB  = 4'd3,
    CTR_SHORTSB = 4'd4,
    CTR_PIPE    = 4'd5,
    CTR_WAIT    = 4'd6,
    CTR_OTHER   = 4'd7
  } ctr_id_e;

  // stall one-hot bit index = counter address - STALL_BASE
  localparam int STALL_BASE = 2;
endpackage

// File: rtl/warp_classifier.sv
module warp_classifier
  import warp_stall_stats_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic                 elig,
  input  logic                 sel,
  input  logic                 long_w,
  input  logic                 short_w,
  input  logic                 pipe_w,
  input  logic                 dep_w,
  output logic                 issued,
  output logic [NUM_STALL-1:0] cat
);
  always_comb begin
    cat    = '0;
    issued = 1'b0;
    if (valid) begin
      if (sel)          issued = 1'b1;
      else if (elig)    cat[CTR_NOTSEL  - STALL_BASE] = 1'b1;
      else if (long_w)  cat[CTR_LONGSB  - STALL_BASE] = 1'b1;
      else if (short_w) cat[CTR_SHORTSB - STALL_BASE] = 1'b1;
      else if (pipe_w)  cat[CTR_PIPE    - STALL_BASE] = 1'b1;
      else if (dep_w)   cat[CTR_WAIT    - STALL_BASE] = 1'b1;
      else              cat[CTR_OTHER   - STALL_BASE] = 1'b1;
    end
  end

  // R8: empty slot contributes nothing
  a_r8_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (cat == '0 && !issued));
  // R2: exactly one outcome per resident warp
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ($countones({cat, issued}) == 1));
endmodule

// File: rtl/stat_tally.sv
module stat_tally
  import warp_stall_stats_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int INC_W     = $clog2(NUM_WARPS + 1)
) (
  input  logic [NUM_WARPS-1:0][NUM_STALL-1:0] cat,
  input  logic [NUM_WARPS-1:0]                issued,
  output logic [NUM_CNT-1:0][INC_W-1:0]       inc
);
  always_comb begin
    inc = '0;
    inc[CTR_ISSUE] = INC_W'(|issued);
    inc[CTR_EMPTY] = INC_W'(~|issued);
    for (int c = 0; c < NUM_STALL; c++) begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        inc[c + STALL_BASE] = inc[c + STALL_BASE] + INC_W'(cat[w][c]);
      end
    end
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W     = 32,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     cnt
);
  logic [W:0]   sum;
  logic [W-1:0] cnt_nxt;
  logic         en;

  always_comb begin
    sum = {1'b0, cnt} + (W+1)'(inc);
    en  = clr | (inc != '0);
    if (clr)         cnt_nxt = '0;
    else if (sum[W]) cnt_nxt = '1;
    else             cnt_nxt = sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= cnt_nxt;
  end

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt >= $past(cnt));
  a_r9_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == '1) |=> cnt == '1);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/warp_stall_stats.sv
module warp_stall_stats
  import warp_stall_stats_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int CNT_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [NUM_WARPS-1:0] warp_valid,
  input  logic [NUM_WARPS-1:0] warp_elig,
  input  logic [NUM_WARPS-1:0] warp_sel,
  input  logic [NUM_WARPS-1:0] wait_long_mem,
  input  logic [NUM_WARPS-1:0] wait_shared_mem,
  input  logic [NUM_WARPS-1:0] mem_pipe_full,
  input  logic [NUM_WARPS-1:0] dep_wait,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [CNT_W-1:0]     rd_data
);
  localparam int INC_W = $clog2(NUM_WARPS + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [NUM_WARPS-1:0][NUM_STALL-1:0] cat;
  logic [NUM_WARPS-1:0]                issued;
  logic [NUM_CNT-1:0][INC_W-1:0]       inc;
  logic [NUM_CNT-1:0][CNT_W-1:0]       cnt_val;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    warp_classifier u_cls (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .valid   (warp_valid[w]),
      .elig    (warp_elig[w]),
      .sel     (warp_sel[w]),
      .long_w  (wait_long_mem[w]),
      .short_w (wait_shared_mem[w]),
      .pipe_w  (mem_pipe_full[w]),
      .dep_w   (dep_wait[w]),
      .issued  (issued[w]),
      .cat     (cat[w])
    );
  end

  stat_tally #(.NUM_WARPS(NUM_WARPS), .INC_W(INC_W)) u_tally (
    .cat    (cat),
    .issued (issued),
    .inc    (inc)
  );

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    sat_counter #(.W(CNT_W), .INC_W(INC_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (clr),
      .inc   (inc[c]),
      .cnt   (cnt_val[c])
    );
  end

  // registered read port
  logic [CNT_W-1:0] rd_nxt;
  always_comb begin
    rd_nxt = '0;
    for (int c = 0; c < NUM_CNT; c++) begin
      if (rd_addr == ADDR_W'(c)) rd_nxt = cnt_val[c];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_data <= '0;
    else             rd_data <= rd_nxt;
  end

  // R1/R8: stall increments plus issuing warps account for every resident warp
  logic [31:0] stall_sum;
  always_comb begin
    stall_sum = '0;
    for (int c = STALL_BASE; c < NUM_CNT; c++) stall_sum = stall_sum + 32'(inc[c]);
  end

  a_r8_conserve: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall_sum + 32'($countones(warp_valid & warp_sel)) == 32'($countones(warp_valid)));
  a_r1_slot_once: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (inc[CTR_ISSUE] + inc[CTR_EMPTY]) == INC_W'(1));
endmodule

// File: tb/warp_stall_stats_tb.sv
module warp_stall_stats_tb;
  localparam int NW = 4;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr;
  logic [NW-1:0] v, e, s, l, sh, p, w;
  logic [3:0]    rd_addr;
  logic [CW-1:0] rd_data;
  int            total = 0;
  int            bad = 0;
  bit            done = 0;

  always #4 clk = ~clk;

  warp_stall_stats #(.NUM_WARPS(NW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .warp_valid(v), .warp_elig(e), .warp_sel(s),
    .wait_long_mem(l), .wait_shared_mem(sh), .mem_pipe_full(p), .dep_wait(w),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic idle();
    v = '0; e = '0; s = '0; l = '0; sh = '0; p = '0; w = '0;
  endtask

  // clear, then hold a pattern for n edges; returns at a falling edge with inputs idle
  task automatic apply(input logic [NW-1:0] vv, ee, ss, ll, hh, pp, ww, input int n);
    @(negedge clk); idle(); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    v = vv; e = ee; s = ss; l = ll; sh = hh; p = pp; w = ww;
    repeat (n) @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [3:0] a, input int exp, input string req);
    rd_addr = a;
    @(posedge clk); #1;
    total++;
    if (rd_data !== CW'(exp)) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%0d expected=%0d", req, a, rd_data, exp);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    rd(4'd0, 0, "R1 reset issue");
    rd(4'd3, 0, "R3 reset long");
  endtask

  task automatic t_issue();
    apply(4'b1111, 4'b1111, 4'b0001, '0, '0, '0, '0, 5);
    rd(4'd1, 0, "R1 empty");
    rd(4'd0, 5, "R1 issue");
    rd(4'd2, 15, "R2 notsel");
  endtask

  task automatic t_empty();
    apply(4'b0011, '0, '0, 4'b0001, 4'b0010, '0, '0, 4);
    rd(4'd1, 4, "R1 empty");
    rd(4'd0, 0, "R1 issue");
    rd(4'd3, 4, "R3 long");
    rd(4'd4, 4, "R4 short");
  endtask

  task automatic t_priority();
    apply(4'b1111, '0, '0, 4'b0001, 4'b0011, 4'b0111, 4'b1111, 3);
    rd(4'd1, 3, "R1 empty");
    rd(4'd3, 3, "R3 long");
    rd(4'd4, 3, "R4 short");
    rd(4'd5, 3, "R5 pipe");
    rd(4'd6, 3, "R6 wait");
    rd(4'd7, 0, "R7 other");
  endtask

  task automatic t_elig_over_stall();
    apply(4'b1111, 4'b0011, '0, 4'b1111, '0, '0, '0, 2);
    rd(4'd2, 4, "R2 notsel");
    rd(4'd3, 4, "R3 long");
  endtask

  task automatic t_invalid();
    apply(4'b0101, 4'b1010, 4'b0010, 4'b1010, 4'b1010, 4'b1010, 4'b1010, 2);
    rd(4'd1, 2, "R8 empty");
    rd(4'd0, 0, "R8 issue");
    rd(4'd7, 4, "R7 other");
    rd(4'd3, 0, "R8 long");
    rd(4'd2, 0, "R8 notsel");
  endtask

  task automatic t_saturate();
    apply(4'b1111, '0, '0, 4'b1111, '0, '0, '0, 70);
    rd(4'd1, 70, "R9 empty");
    rd(4'd3, 255, "R9 long sat");
  endtask

  task automatic t_clear_wins();
    apply(4'b1111, '0, '0, 4'b1111, '0, '0, '0, 3);
    v = 4'b1111; l = 4'b1111; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    repeat (2) @(negedge clk);
    idle();
    rd(4'd1, 2, "R10 empty");
    rd(4'd3, 8, "R10 long");
  endtask

  task automatic t_read_port();
    apply(4'b0001, '0, '0, '0, '0, '0, 4'b0001, 6);
    rd(4'd6, 6, "R11 wait");
    rd(4'd9, 0, "R11 out of range");
    rd(4'd15, 0, "R11 out of range");
    rd(4'd6, 6, "R11 reread");
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; rd_addr = '0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_issue();
    t_empty();
    t_priority();
    t_elig_over_stall();
    t_invalid();
    t_saturate();
    t_clear_wins();
    t_read_port();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule